// File: doc/BRIEF.md
# Pin Port Register Controller

This block holds the configuration state for one 32-pin I/O port and builds, pin by pin, the value and output-enable that reach each pad. Software reaches it through a single-cycle register bus with an address, write data, a write strobe and combinational read data. Every configuration register has several write addresses. One loads the whole word. The others set, clear or (for the output value only) invert just the bits named in a mask. A single pin can therefore change without a read-modify-write sequence. A global pin number n lives in port n / 32 at bit n mod 32.

Each pin has one owner. If its ownership bit is set, the port's own output-value and driver-enable registers drive the pad. If the bit is clear, one of three peripheral functions drives the pad. Two select bits per pin pick the function. A read-only register returns the live input level of every pad.

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset every register reads zero, pad_gpio_own is all zero, and every pad follows peripheral function A (pad_out = fa_out, pad_oe = fa_oe).
- R2: Address bits [4:2] select the register: 0 ownership, 1 select-low, 2 select-high, 3 driver enable, 4 output value, 5 pad level, 6 and 7 unmapped. Bits [1:0] select the access: 0 base, 1 set, 2 clear, 3 toggle. A base write loads the full word and a base read returns it. Set, clear and toggle addresses read as zero. Unmapped addresses read zero and their writes change nothing.
- R3: A write to a set address forces the masked bits to 1 and leaves the other bits unchanged.
- R4: A write to a clear address forces the masked bits to 0 and leaves the other bits unchanged.
- R5: A toggle write to the output-value register inverts the masked bits. A toggle write to any other register has no effect.
- R6: A base read of register 5 returns pad_in in the same cycle. Writes to register 5 alter no register.
- R7: When a pin's ownership bit is 1, pad_out takes the output-value bit and pad_oe takes the driver-enable bit.
- R8: When a pin's ownership bit is 0, its select pair {high,low} picks the driver: 00 gives function A, 01 gives B, 10 gives C, and the reserved 11 gives A. The chosen function supplies both the pad value and the pad enable.
- R9: pad_gpio_own equals the ownership register bit for bit.
- R10: A write shows in the register on the rising edge where bus_we is sampled high. With bus_we low, no register changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register index and access kind |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Pad output buffer enable |
| pad_gpio_own | output | 32 | 1 where the port owns the pin |
| fa_out | input | 32 | Function A output values |
| fa_oe | input | 32 | Function A output enables |
| fb_out | input | 32 | Function B output values |
| fb_oe | input | 32 | Function B output enables |
| fc_out | input | 32 | Function C output values |
| fc_oe | input | 32 | Function C output enables |

## Verification
The assertions check four things on every cycle. Set, clear and toggle writes must change only the masked bits. An idle bus must leave every register unchanged. Alias addresses must read zero. The pad mux must obey ownership and treat the reserved select code as function A. Only the bench scenarios can show the whole address map and the register contents. These include the toggle writes that are ignored on non-output registers, the silent writes to unmapped and read-only indices, and all four select codes applied at once across the port against independent function patterns.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

    typedef enum logic [1:0] {
        AC_BASE = 2'd0,
        AC_SET  = 2'd1,
        AC_CLR  = 2'd2,
        AC_TGL  = 2'd3
    } access_e;

    typedef enum logic [2:0] {
        RX_OWN    = 3'd0,
        RX_SEL_LO = 3'd1,
        RX_SEL_HI = 3'd2,
        RX_DRV    = 3'd3,
        RX_OVAL   = 3'd4,
        RX_LEVEL  = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        FN_A   = 2'b00,
        FN_B   = 2'b01,
        FN_C   = 2'b10,
        FN_RSV = 2'b11
    } func_e;

endpackage

// File: rtl/pin_port_regfile.sv
module pin_port_regfile
    import pin_port_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  own,
    output logic [W-1:0]  sel_lo,
    output logic [W-1:0]  sel_hi,
    output logic [W-1:0]  drv,
    output logic [W-1:0]  oval
);
    localparam int IDX_W = AW - 2;

    typedef struct packed {
        logic [W-1:0] own;
        logic [W-1:0] sel_lo;
        logic [W-1:0] sel_hi;
        logic [W-1:0] drv;
        logic [W-1:0] oval;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [IDX_W-1:0] idx;
    access_e          acc;

    assign idx = wr_addr[AW-1:2];
    assign acc = access_e'(wr_addr[1:0]);

    function automatic logic [W-1:0] upd(input logic [W-1:0] cur,
                                         input logic [W-1:0] mask,
                                         input access_e      a,
                                         input logic         tgl_ok);
        case (a)
            AC_BASE: upd = mask;
            AC_SET:  upd = cur | mask;
            AC_CLR:  upd = cur & ~mask;
            default: upd = tgl_ok ? (cur ^ mask) : cur;
        endcase
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (idx == IDX_W'(RX_OWN))
                regs_d.own = upd(regs_q.own, wr_data, acc, 1'b0);
            if (idx == IDX_W'(RX_SEL_LO))
                regs_d.sel_lo = upd(regs_q.sel_lo, wr_data, acc, 1'b0);
            if (idx == IDX_W'(RX_SEL_HI))
                regs_d.sel_hi = upd(regs_q.sel_hi, wr_data, acc, 1'b0);
            if (idx == IDX_W'(RX_DRV))
                regs_d.drv = upd(regs_q.drv, wr_data, acc, 1'b0);
            if (idx == IDX_W'(RX_OVAL))
                regs_d.oval = upd(regs_q.oval, wr_data, acc, 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign own    = regs_q.own;
    assign sel_lo = regs_q.sel_lo;
    assign sel_hi = regs_q.sel_hi;
    assign drv    = regs_q.drv;
    assign oval   = regs_q.oval;

    AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc == AC_SET && idx == IDX_W'(RX_OVAL))
        |=> ((regs_q.oval & $past(wr_data)) == $past(wr_data))); // R3
    AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc == AC_SET && idx == IDX_W'(RX_DRV))
        |=> ((regs_q.drv & ~$past(wr_data)) == ($past(regs_q.drv) & ~$past(wr_data)))); // R3
    AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc == AC_CLR && idx == IDX_W'(RX_OWN))
        |=> ((regs_q.own & $past(wr_data)) == '0)); // R4
    AST_TGL_OVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc == AC_TGL && idx == IDX_W'(RX_OVAL))
        |=> (regs_q.oval == ($past(regs_q.oval) ^ $past(wr_data)))); // R5
    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)); // R10

endmodule

// File: rtl/pin_port_rdmux.sv
module pin_port_rdmux
    import pin_port_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  own,
    input  logic [W-1:0]  sel_lo,
    input  logic [W-1:0]  sel_hi,
    input  logic [W-1:0]  drv,
    input  logic [W-1:0]  oval,
    input  logic [W-1:0]  level,
    output logic [W-1:0]  rd_data
);
    localparam int IDX_W = AW - 2;

    logic [IDX_W-1:0] idx;
    assign idx = rd_addr[AW-1:2];

    always_comb begin
        rd_data = '0;
        if (access_e'(rd_addr[1:0]) == AC_BASE) begin
            if      (idx == IDX_W'(RX_OWN))    rd_data = own;
            else if (idx == IDX_W'(RX_SEL_LO)) rd_data = sel_lo;
            else if (idx == IDX_W'(RX_SEL_HI)) rd_data = sel_hi;
            else if (idx == IDX_W'(RX_DRV))    rd_data = drv;
            else if (idx == IDX_W'(RX_OVAL))   rd_data = oval;
            else if (idx == IDX_W'(RX_LEVEL))  rd_data = level;
        end
    end

endmodule

// File: rtl/pin_port_padmux.sv
module pin_port_padmux
    import pin_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] sel_lo,
    input  logic [W-1:0] sel_hi,
    input  logic [W-1:0] oval,
    input  logic [W-1:0] drv,
    input  logic [W-1:0] fa_out,
    input  logic [W-1:0] fa_oe,
    input  logic [W-1:0] fb_out,
    input  logic [W-1:0] fb_oe,
    input  logic [W-1:0] fc_out,
    input  logic [W-1:0] fc_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        func_e fn;
        assign fn = func_e'({sel_hi[i], sel_lo[i]});

        always_comb begin
            if (own[i]) begin
                pad_out[i] = oval[i];
                pad_oe[i]  = drv[i];
            end else begin
                case (fn)
                    FN_B: begin
                        pad_out[i] = fb_out[i];
                        pad_oe[i]  = fb_oe[i];
                    end
                    FN_C: begin
                        pad_out[i] = fc_out[i];
                        pad_oe[i]  = fc_oe[i];
                    end
                    default: begin
                        pad_out[i] = fa_out[i];
                        pad_oe[i]  = fa_oe[i];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
    import pin_port_pkg::*;
#(
    parameter int NPIN = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_we,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_gpio_own,
    input  logic [NPIN-1:0] fa_out,
    input  logic [NPIN-1:0] fa_oe,
    input  logic [NPIN-1:0] fb_out,
    input  logic [NPIN-1:0] fb_oe,
    input  logic [NPIN-1:0] fc_out,
    input  logic [NPIN-1:0] fc_oe
);
    logic [NPIN-1:0] own_q, sel_lo_q, sel_hi_q, drv_q, oval_q;

    pin_port_regfile #(.W(NPIN), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .own     (own_q),
        .sel_lo  (sel_lo_q),
        .sel_hi  (sel_hi_q),
        .drv     (drv_q),
        .oval    (oval_q)
    );

    pin_port_rdmux #(.W(NPIN), .AW(AW)) u_rd (
        .rd_addr (bus_addr),
        .own     (own_q),
        .sel_lo  (sel_lo_q),
        .sel_hi  (sel_hi_q),
        .drv     (drv_q),
        .oval    (oval_q),
        .level   (pad_in),
        .rd_data (bus_rdata)
    );

    pin_port_padmux #(.W(NPIN)) u_mux (
        .own     (own_q),
        .sel_lo  (sel_lo_q),
        .sel_hi  (sel_hi_q),
        .oval    (oval_q),
        .drv     (drv_q),
        .fa_out  (fa_out),
        .fa_oe   (fa_oe),
        .fb_out  (fb_out),
        .fb_oe   (fb_oe),
        .fc_out  (fc_out),
        .fc_oe   (fc_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_gpio_own = own_q;

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R2
    AST_GPIO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & pad_gpio_own) == (oval_q & own_q)) &&
        ((pad_oe & pad_gpio_own) == (drv_q & own_q))); // R7
    AST_RSV_IS_A: assert property (@(posedge clk) disable iff (!rst_n)
        ((~own_q & sel_lo_q & sel_hi_q & ((pad_out ^ fa_out) | (pad_oe ^ fa_oe))) == '0)); // R8
    AST_FUNC_B: assert property (@(posedge clk) disable iff (!rst_n)
        ((~own_q & sel_lo_q & ~sel_hi_q & ((pad_out ^ fb_out) | (pad_oe ^ fb_oe))) == '0)); // R8

endmodule

// File: tb/pin_port_ctrl_bench.sv
module pin_port_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = 32'h1234_5678;
    logic [31:0] pad_out, pad_oe, pad_gpio_own;
    logic [31:0] fa_out = 32'hA5A5_0F0F, fa_oe = 32'h00FF_F00F;
    logic [31:0] fb_out = 32'h5A5A_F0F0, fb_oe = 32'hFF00_0FF0;
    logic [31:0] fc_out = 32'hC3C3_3C3C, fc_oe = 32'h0F0F_F0F0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] e_own, e_lo, e_hi, e_drv, e_oval;
    logic [31:0] seed = 32'hDEAD_BEEF;

    always #5 clk = ~clk;

    pin_port_ctrl u_pin_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_gpio_own(pad_gpio_own),
        .fa_out(fa_out), .fa_oe(fa_oe), .fb_out(fb_out), .fb_oe(fb_oe),
        .fc_out(fc_out), .fc_oe(fc_oe)
    );

    function automatic logic [31:0] rng();
        logic [31:0] s;
        s = seed;
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        seed = s;
        return s;
    endfunction

    function automatic logic [31:0] acc_upd(input logic [31:0] cur, input int al,
                                            input logic [31:0] d, input bit tgl_ok);
        case (al)
            0: return d;
            1: return cur | d;
            2: return cur & ~d;
            default: return tgl_ok ? (cur ^ d) : cur;
        endcase
    endfunction

    function automatic void model(input int idx, input int al, input logic [31:0] d);
        case (idx)
            0: e_own  = acc_upd(e_own, al, d, 1'b0);
            1: e_lo   = acc_upd(e_lo, al, d, 1'b0);
            2: e_hi   = acc_upd(e_hi, al, d, 1'b0);
            3: e_drv  = acc_upd(e_drv, al, d, 1'b0);
            4: e_oval = acc_upd(e_oval, al, d, 1'b1);
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int idx, input int al);
        if (al != 0) return 32'h0;
        case (idx)
            0: return e_own;
            1: return e_lo;
            2: return e_hi;
            3: return e_drv;
            4: return e_oval;
            5: return pad_in;
            default: return 32'h0;
        endcase
    endfunction

    task automatic report(input string tag, input string what,
                          input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic wr(input int idx, input int al, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 5'(idx * 4 + al);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model(idx, al, d);
    endtask

    task automatic chk_rd(input int idx, input int al, input string tag);
        bus_addr = 5'(idx * 4 + al);
        #1;
        report(tag, $sformatf("read idx=%0d acc=%0d", idx, al), bus_rdata, exp_rd(idx, al));
    endtask

    task automatic chk_all_regs(input string tag);
        for (int k = 0; k < 8; k++) chk_rd(k, 0, tag);
    endtask

    task automatic chk_pads(input string tag);
        logic [31:0] eo, ee;
        for (int i = 0; i < 32; i++) begin
            if (e_own[i]) begin
                eo[i] = e_oval[i];
                ee[i] = e_drv[i];
            end else begin
                case ({e_hi[i], e_lo[i]})
                    2'b01:   begin eo[i] = fb_out[i]; ee[i] = fb_oe[i]; end
                    2'b10:   begin eo[i] = fc_out[i]; ee[i] = fc_oe[i]; end
                    default: begin eo[i] = fa_out[i]; ee[i] = fa_oe[i]; end
                endcase
            end
        end
        #1;
        report(tag, "pad_out", pad_out, eo);
        report(tag, "pad_oe", pad_oe, ee);
        report({tag, " R9"}, "pad_gpio_own", pad_gpio_own, e_own);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        e_own = '0; e_lo = '0; e_hi = '0; e_drv = '0; e_oval = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents and pads on function A
        chk_all_regs("R1");
        chk_pads("R1");

        // R8: all four select codes across the port
        wr(1, 0, 32'h3333_3333);
        wr(2, 0, 32'h0F0F_0F0F);
        chk_pads("R8");

        // R7: half the pins owned by the port
        wr(0, 0, 32'hFFFF_0000);
        wr(4, 0, 32'h8421_8421);
        wr(3, 0, 32'h00FF_00FF);
        chk_pads("R7");

        // R5: toggle on non-output registers ignored
        for (int k = 0; k < 4; k++) begin
            wr(k, 3, 32'hFFFF_FFFF);
            chk_all_regs("R5");
        end
        chk_pads("R5");

        // R6 and R2: writes to pad level and unmapped indices ignored
        for (int k = 5; k < 8; k++)
            for (int a = 0; a < 4; a++) begin
                wr(k, a, 32'h5555_AAAA);
                chk_all_regs(k == 5 ? "R6" : "R2");
            end
        pad_in = 32'hCAFE_F00D;
        chk_rd(5, 0, "R6");

        // Sweep of every address with varied masks
        for (int it = 0; it < 40; it++)
            for (int k = 0; k < 8; k++)
                for (int a = 0; a < 4; a++) begin
                    string tg;
                    logic [31:0] d;
                    d = rng();
                    pad_in = rng();
                    wr(k, a, d);
                    tg = (a == 1) ? "R3" : (a == 2) ? "R4" : (a == 3) ? "R5" : "R2";
                    chk_all_regs(tg);
                    chk_rd(k, a, "R2");
                    chk_pads("R8");
                    // R10: idle bus with changing address and data
                    @(negedge clk);
                    bus_addr  = 5'(rng());
                    bus_wdata = rng();
                    @(negedge clk);
                    chk_all_regs("R10");
                end

        finish_run();
    end

endmodule